// File: doc/BRIEF.md
# Memory Window Base Register and Address-Hit Decoder

This block is the configuration-side address decoder of a bus target. It holds one memory base register and two space-enable bits in a command word. Software writes the base through a dword-addressed configuration port that honours byte enables. It can also find the window size by writing all ones to the base and reading the value back. On the bus side, the block compares each qualified memory access against the programmed window and raises a registered hit one clock later.

The base register defines a window of 2^SIZE_LOG2 bytes. Only the bits at and above the size boundary can be written. Bits below the boundary read back as zero. The four lowest bits are fixed attribute bits. A base whose writable bits are all zero counts as unprogrammed. The block never claims an access while the base is unprogrammed, even when the memory enable bit is set. Software may therefore set the enable bits before or after it programs the base without risk of a stray claim.

The decision is made by a three-state machine that follows the next-cycle values of the enable bit and the base register:
- DEC_OFF: memory decoding is disabled.
- DEC_UNSET: decoding is enabled but the base is zero.
- DEC_ARMED: decoding is enabled and the base is nonzero.

The transitions are:
- OFF to UNSET: enable set while the base is zero.
- OFF to ARMED: enable set with a nonzero base.
- UNSET to ARMED: base programmed.
- ARMED to UNSET: base cleared.
- UNSET or ARMED to OFF: enable cleared, or a soft clear.

Only DEC_ARMED can produce a hit.

Top module: `bar_decoder_top`

## Requirements
- R1: After rst_n is deasserted, both enable bits are 0, the base is 0 and hit is 0. A read of the command dword returns 0, and a read of the base dword returns only the attribute bits.
- R2: Base-dword bits [3:0] always read as the attribute value and ignore writes. The attribute value has bit 0 = 0 (memory), bits [2:1] = 00 (32-bit) and bit 3 = PREFETCH. With the default parameters the value is 4'h8.
- R3: hit is asserted only when the memory enable bit (command dword bit 1) was set in the cycle the access was presented.
- R4: While base bits [31:SIZE_LOG2] are all zero, hit is never asserted, whatever the enable bits hold or the bus address is.
- R5: If memory enable is set while the base is zero, no access is claimed. Once a nonzero base is written, a matching access is claimed from the next access cycle onward.
- R6: hit rises exactly one clock after an access with bus_valid=1, bus_is_mem=1, mem enable set, a nonzero base and bus_addr[31:SIZE_LOG2] equal to the base. I/O-type accesses, invalid cycles and mismatched addresses produce hit=0.
- R7: Base-dword bits [SIZE_LOG2-1:4] read as 0 and ignore writes. After an all-ones write to the base dword (dword 4), a read returns ~(2^SIZE_LOG2-1) OR the attribute value, which is 32'hFFFFF008 with the defaults.
- R8: A configuration write changes only the bytes whose cfg_be bit is set. A write with cfg_be = 0 changes nothing.
- R9: A cycle with soft_clr=1 clears both enable bits and the base. hit is 0 in the following cycle.
- R10: The I/O enable bit (command dword, dword 1, bit 0) can be written and read back, and has no effect on hit.
- R11: cfg_rdata holds the addressed dword one clock after cfg_rd, and 0 after any cycle without cfg_rd. Dwords other than 1 and 4 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of enables and base |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| bus_valid | input | 1 | Bus address cycle qualifier |
| bus_is_mem | input | 1 | 1 = memory transaction, 0 = I/O |
| bus_addr | input | 32 | Bus address |
| hit | output | 1 | Registered window claim |

## Verification
Both hit and cfg_rdata are due one clock after the edge at which their inputs are sampled. A configuration write affects decoding from the very next access cycle. The bench model evaluates each rising edge from the values seen just before that edge. It then compares its expected hit and read data with the ports at the following falling edge, so every comparison lands in the cycle the result is due. The directed readback checks issue their read, wait one more edge, and then sample.

// File: rtl/bar_pkg.sv
package bar_pkg;

    typedef enum logic [1:0] {
        DEC_OFF   = 2'd0,
        DEC_UNSET = 2'd1,
        DEC_ARMED = 2'd2
    } dec_state_e;

    function automatic logic [3:0] attr_bits(input bit prefetch);
        return {prefetch, 2'b00, 1'b0};
    endfunction

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg #(
    parameter int unsigned DW_AW     = 6,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CMD_DWORD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr,
    input  logic [DW_AW-1:0]  addr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0] wdata,
    output logic              mem_en_q,
    output logic              io_en_q,
    output logic              mem_en_d
);

    logic io_en_d;
    logic sel;
    logic unused_cmd;

    assign sel        = wr && (addr == DW_AW'(CMD_DWORD)) && be[0];
    assign unused_cmd = ^{be, wdata};

    always_comb begin
        mem_en_d = mem_en_q;
        io_en_d  = io_en_q;
        if (soft_clr) begin
            mem_en_d = 1'b0;
            io_en_d  = 1'b0;
        end else if (sel) begin
            mem_en_d = wdata[1];
            io_en_d  = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_en_q <= 1'b0;
            io_en_q  <= 1'b0;
        end else begin
            mem_en_q <= mem_en_d;
            io_en_q  <= io_en_d;
        end
    end

endmodule

// File: rtl/cfg_base_reg.sv
module cfg_base_reg #(
    parameter int unsigned DW_AW      = 6,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SIZE_LOG2  = 12,
    parameter int unsigned BASE_DWORD = 4,
    parameter bit          PREFETCH   = 1'b1,
    localparam int unsigned BASE_W    = ADDR_W - SIZE_LOG2,
    localparam int unsigned NBYTES    = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr,
    input  logic [DW_AW-1:0]  addr,
    input  logic [NBYTES-1:0] be,
    input  logic [ADDR_W-1:0] wdata,
    output logic [BASE_W-1:0] base_q,
    output logic [BASE_W-1:0] base_d,
    output logic              base_nz_d,
    output logic [ADDR_W-1:0] read_word
);

    localparam logic [3:0] ATTR = bar_pkg::attr_bits(PREFETCH);

    logic              sel;
    logic [BASE_W-1:0] merged;
    logic              unused_base;

    assign sel         = wr && (addr == DW_AW'(BASE_DWORD));
    assign unused_base = ^{be, wdata};

    for (genvar i = 0; i < BASE_W; i++) begin : g_bit
        localparam int unsigned LANE = (i + SIZE_LOG2) / 8;
        assign merged[i] = be[LANE] ? wdata[i + SIZE_LOG2] : base_q[i];
    end

    always_comb begin
        base_d = base_q;
        if (soft_clr) begin
            base_d = '0;
        end else if (sel) begin
            base_d = merged;
        end
    end

    assign base_nz_d = |base_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

    assign read_word = {base_q, {(SIZE_LOG2-4){1'b0}}, ATTR};

endmodule

// File: rtl/addr_hit_fsm.sv
module addr_hit_fsm #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned SIZE_LOG2 = 12,
    localparam int unsigned BASE_W   = ADDR_W - SIZE_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              mem_en_d,
    input  logic              base_nz_d,
    input  logic [BASE_W-1:0] base_q,
    input  logic              bus_valid,
    input  logic              bus_is_mem,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit
);

    import bar_pkg::*;

    dec_state_e state_q;
    dec_state_e state_d;
    logic       hit_d;
    logic       unused_low;

    assign unused_low = ^bus_addr[SIZE_LOG2-1:0];

    // next state follows the next-cycle register values
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_OFF: begin
                if (mem_en_d) state_d = base_nz_d ? DEC_ARMED : DEC_UNSET;
            end
            DEC_UNSET: begin
                if (!mem_en_d)     state_d = DEC_OFF;
                else if (base_nz_d) state_d = DEC_ARMED;
            end
            DEC_ARMED: begin
                if (!mem_en_d)      state_d = DEC_OFF;
                else if (!base_nz_d) state_d = DEC_UNSET;
            end
            default: state_d = DEC_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEC_OFF;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        hit_d = 1'b0;
        unique case (state_q)
            DEC_ARMED: hit_d = bus_valid && bus_is_mem &&
                               (bus_addr[ADDR_W-1:SIZE_LOG2] == base_q);
            default:   hit_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hit <= 1'b0;
        else if (soft_clr) hit <= 1'b0;
        else               hit <= hit_d;
    end

endmodule

// File: rtl/bar_decoder_top.sv
module bar_decoder_top #(
    parameter int unsigned DW_AW      = 6,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SIZE_LOG2  = 12,
    parameter int unsigned CMD_DWORD  = 1,
    parameter int unsigned BASE_DWORD = 4,
    parameter bit          PREFETCH   = 1'b1,
    localparam int unsigned BASE_W    = ADDR_W - SIZE_LOG2,
    localparam int unsigned NBYTES    = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [DW_AW-1:0]  cfg_addr,
    input  logic [NBYTES-1:0] cfg_be,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              bus_valid,
    input  logic              bus_is_mem,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit
);

    logic              mem_en_q;
    logic              io_en_q;
    logic              mem_en_d;
    logic [BASE_W-1:0] base_q;
    logic [BASE_W-1:0] base_d;
    logic              base_nz_d;
    logic              base_nz;
    logic [ADDR_W-1:0] bar_word;
    logic [ADDR_W-1:0] rd_mux;
    logic              unused_top;

    assign base_nz    = |base_q;
    assign unused_top = ^base_d;

    cfg_cmd_reg #(
        .DW_AW(DW_AW), .DATA_W(ADDR_W), .CMD_DWORD(CMD_DWORD)
    ) i_cmd (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(cfg_wr),
        .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
        .mem_en_q(mem_en_q), .io_en_q(io_en_q), .mem_en_d(mem_en_d)
    );

    cfg_base_reg #(
        .DW_AW(DW_AW), .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2),
        .BASE_DWORD(BASE_DWORD), .PREFETCH(PREFETCH)
    ) i_base (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr(cfg_wr),
        .addr(cfg_addr), .be(cfg_be), .wdata(cfg_wdata),
        .base_q(base_q), .base_d(base_d), .base_nz_d(base_nz_d),
        .read_word(bar_word)
    );

    addr_hit_fsm #(
        .ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .mem_en_d(mem_en_d), .base_nz_d(base_nz_d), .base_q(base_q),
        .bus_valid(bus_valid), .bus_is_mem(bus_is_mem), .bus_addr(bus_addr),
        .hit(hit)
    );

    always_comb begin
        rd_mux = '0;
        if (cfg_addr == DW_AW'(CMD_DWORD)) begin
            rd_mux = {{(ADDR_W-2){1'b0}}, mem_en_q, io_en_q};
        end else if (cfg_addr == DW_AW'(BASE_DWORD)) begin
            rd_mux = bar_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_mux;
        else             cfg_rdata <= '0;
    end

endmodule

// File: rtl/bar_decoder_chk.sv
module bar_decoder_chk #(
    parameter int unsigned DW_AW      = 6,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned BASE_DWORD = 4,
    parameter bit          PREFETCH   = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_clr,
    input logic              cfg_rd,
    input logic [DW_AW-1:0]  cfg_addr,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              bus_valid,
    input logic              bus_is_mem,
    input logic              mem_en,
    input logic              io_en,
    input logic              base_nz,
    input logic              hit
);

    localparam logic [3:0] ATTR = bar_pkg::attr_bits(PREFETCH);

    a_r3_hit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(mem_en));

    a_r4_no_hit_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(base_nz));

    a_r6_hit_needs_mem_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(bus_valid && bus_is_mem));

    a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!mem_en && !io_en && !base_nz && !hit));

    a_r2_attr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_rd && (cfg_addr == DW_AW'(BASE_DWORD))) |-> (cfg_rdata[3:0] == ATTR));

    a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_rd) |-> (cfg_rdata == '0));

endmodule

bind bar_decoder_top bar_decoder_chk #(
    .DW_AW(DW_AW), .ADDR_W(ADDR_W), .BASE_DWORD(BASE_DWORD), .PREFETCH(PREFETCH)
) i_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_is_mem(bus_is_mem), .mem_en(mem_en_q), .io_en(io_en_q),
    .base_nz(base_nz), .hit(hit)
);

// File: tb/test_bar_decoder_top.sv
`timescale 1ns/1ps
module test_bar_decoder_top;

    localparam int          SZ   = 12;
    localparam logic [31:0] MASK = ~((32'd1 << SZ) - 32'd1);
    localparam logic [31:0] ATTR = 32'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic        bus_is_mem = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        hit;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    bar_decoder_top i_bar_decoder_top (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_wr(cfg_wr),
        .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
        .bus_is_mem(bus_is_mem), .bus_addr(bus_addr), .hit(hit)
    );

    // behavioural reference model
    bit          m_mem, m_io;
    logic [31:0] m_bar;
    bit          exp_hit;
    logic [31:0] exp_rd;

    always @(posedge clk) begin
        logic [31:0] nb;
        if (!rst_n) begin
            m_mem = 0; m_io = 0; m_bar = 0; exp_hit = 0; exp_rd = 0;
        end else begin
            if (cfg_rd) begin
                if (cfg_addr == 6'd1)      exp_rd = {30'd0, m_mem, m_io};
                else if (cfg_addr == 6'd4) exp_rd = m_bar | ATTR;
                else                       exp_rd = 0;
            end else exp_rd = 0;
            exp_hit = !soft_clr && m_mem && (m_bar != 0) && bus_valid && bus_is_mem
                      && ((bus_addr & MASK) == m_bar);
            if (soft_clr) begin
                m_mem = 0; m_io = 0; m_bar = 0;
            end else if (cfg_wr) begin
                if (cfg_addr == 6'd1 && cfg_be[0]) begin
                    m_mem = cfg_wdata[1]; m_io = cfg_wdata[0];
                end
                if (cfg_addr == 6'd4) begin
                    nb = m_bar;
                    for (int b = 0; b < 4; b++)
                        if (cfg_be[b]) nb[b*8 +: 8] = cfg_wdata[b*8 +: 8];
                    m_bar = nb & MASK;
                end
            end
        end
    end

    always @(negedge clk) begin
        n_cmp++;
        if (hit !== exp_hit) begin
            n_bad++;
            $display("FAIL %s hit actual=%0b expected=%0b t=%0t", cur_req, hit, exp_hit, $time);
        end
        n_cmp++;
        if (cfg_rdata !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, cfg_rdata, exp_rd, $time);
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        cfg_wr = 0; cfg_rd = 0; soft_clr = 0; bus_valid = 0; cfg_be = 0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_rd = 0; cfg_addr = a; cfg_be = be; cfg_wdata = d; bus_valid = 0;
        idle();
    endtask

    task automatic bus(input logic [31:0] a, input logic mem);
        @(posedge clk); #1;
        cfg_wr = 0; cfg_rd = 0; bus_valid = 1; bus_is_mem = mem; bus_addr = a;
    endtask

    // direct check against a value from the requirements
    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        cfg_wr = 0; cfg_rd = 1; cfg_addr = a; bus_valid = 0;
        idle();
        @(negedge clk); #0.1;
        n_cmp++;
        if (cfg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s direct read actual=%h expected=%h", req, cfg_rdata, e);
        end
    endtask

    task automatic hit_chk(input logic [31:0] a, input logic mem, input logic e, input string req);
        bus(a, mem);
        idle();
        @(negedge clk); #0.1;
        n_cmp++;
        if (hit !== e) begin
            n_bad++;
            $display("FAIL %s direct hit actual=%0b expected=%0b", req, hit, e);
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        rd_chk(6'd1, 32'h0, "R1");
        rd_chk(6'd4, ATTR, "R1");
        hit_chk(32'h0, 1, 0, "R1");

        cur_req = "R4";
        wr(6'd1, 4'hF, 32'h2);
        hit_chk(32'h0, 1, 0, "R4");
        hit_chk(32'h0000_0100, 1, 0, "R5");
        wr(6'd4, 4'hF, 32'h0000_0FFF);
        rd_chk(6'd4, ATTR, "R7");
        hit_chk(32'h0, 1, 0, "R4");

        cur_req = "R7";
        wr(6'd4, 4'hF, 32'hFFFF_FFFF);
        rd_chk(6'd4, 32'hFFFF_F008, "R7");
        rd_chk(6'd4, 32'hFFFF_F008, "R2");
        hit_chk(32'hFFFF_F123, 1, 1, "R6");

        cur_req = "R6";
        hit_chk(32'hFFFF_F123, 0, 0, "R6");
        hit_chk(32'hFFFE_F123, 1, 0, "R6");
        @(posedge clk); #1 bus_valid = 0; bus_is_mem = 1; bus_addr = 32'hFFFF_F000;
        idle();

        cur_req = "R3";
        wr(6'd1, 4'hF, 32'h1);
        rd_chk(6'd1, 32'h1, "R10");
        hit_chk(32'hFFFF_F123, 1, 0, "R3");

        cur_req = "R8";
        wr(6'd1, 4'h0, 32'h2);
        rd_chk(6'd1, 32'h1, "R8");
        wr(6'd1, 4'h1, 32'h3);
        wr(6'd4, 4'b0100, 32'h00AB_0000);
        rd_chk(6'd4, 32'hFFAB_F008, "R8");
        hit_chk(32'hFFAB_F010, 1, 1, "R10");

        cur_req = "R9";
        @(posedge clk); #1 soft_clr = 1; bus_valid = 1; bus_is_mem = 1; bus_addr = 32'hFFAB_F010;
        idle();
        hit_chk(32'hFFAB_F010, 1, 0, "R9");
        rd_chk(6'd1, 32'h0, "R9");
        rd_chk(6'd4, ATTR, "R9");

        cur_req = "R5";
        wr(6'd4, 4'hF, 32'h8000_0000);
        hit_chk(32'h8000_0004, 1, 0, "R5");
        wr(6'd1, 4'hF, 32'h2);
        hit_chk(32'h8000_0004, 1, 1, "R5");

        cur_req = "R11";
        rd_chk(6'd2, 32'h0, "R11");
        rd_chk(6'd5, 32'h0, "R11");

        cur_req = "R6";
        for (int i = 0; i < 2000; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            @(posedge clk); #1;
            cfg_wr = 0; cfg_rd = 0; soft_clr = 0; bus_valid = 0;
            case (k)
                0: begin cfg_wr = 1; cfg_addr = 6'd1; cfg_be = 4'($urandom); cfg_wdata = $urandom; end
                1: begin cfg_wr = 1; cfg_addr = 6'd4; cfg_be = 4'($urandom);
                         cfg_wdata = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom; end
                2: begin cfg_rd = 1; cfg_addr = 6'($urandom_range(0, 6)); end
                3: soft_clr = ($urandom_range(0, 7) == 0);
                default: begin bus_valid = 1; bus_is_mem = ($urandom_range(0, 4) != 0);
                         bus_addr = ($urandom_range(0, 3) == 0) ? $urandom : (m_bar | 32'($urandom_range(0, 4095))); end
            endcase
        end
        idle();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule